// File: doc/BRIEF.md
# MMU Control Register Bank

This block holds the processor-control registers that govern address translation and exception reporting. It sits on a simple word-addressed read/write bus and keeps nine 32-bit-wide locations. These are the MMU control word, the upper and lower halves of a page-table entry, a page-table assist field, the translation table base, the faulting address, and three event-code registers for traps, exceptions and interrupts.

Two writes have effects beyond storage. Both are aimed at an external translation buffer. Setting the invalidate bit in the control word emits a one-cycle invalidate strobe. That bit is never kept. Writing the page-entry upper word with a new address-space identifier in its low byte emits a one-cycle flush strobe. Several registers keep only part of the written word.

Reads are combinational, so data is valid in the same cycle as the read enable. A read from a location outside the map returns zero and raises an error flag.

Top module: `mmu_ctl_bank`

## Requirements
- R1: After reset every mapped register reads zero and both strobes are low.
- R2: A write to word 0 with bit 2 set makes `inv_pulse` high for exactly the one cycle following the write edge. A write to word 0 with bit 2 clear gives no strobe.
- R3: Word 0 stores every written bit except bit 2, which always reads back as zero.
- R4: A write to word 1 makes `flush_pulse` high for exactly the one cycle after the write edge, but only when bits 7:0 of the new value differ from the stored bits 7:0. Changing only bits 31:8 gives no strobe. All 32 bits are stored.
- R5: Word 3 (page-table assist) keeps only bits 3:0 and reads zero above them.
- R6: Words 6, 7 and 8 (trap, exception and interrupt codes) keep only bits 10:0 and read zero above them.
- R7: Words 2, 4 and 5 (page-entry low, table base, fault address) keep all 32 bits.
- R8: A write to any word address from 9 to 15 changes no register and gives no strobe. A read from such an address returns zero with `rd_err` high. A read from a mapped word has `rd_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe for the addressed word |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| rd_err | output | 1 | Read targeted an unmapped word |
| inv_pulse | output | 1 | One-cycle buffer invalidate strobe |
| flush_pulse | output | 1 | One-cycle flush strobe on identifier change |

## Verification
The bench writes the upper page-entry word several times. It first writes an identifier equal to the stored one, then changes only the upper bits, then changes the low byte. A design that compared the whole word, or compared against the incoming data, would flush on the wrong write. It writes all ones to the control word and reads it back. A design that stored the invalidate bit would return it set. It also checks that the strobe drops after one cycle, which catches a level output. All-ones writes to the masked registers and writes to unmapped addresses, each followed by reading back the whole map, expose a wrong mask width or a decoder that aliases unmapped words onto real registers.

// File: rtl/mmu_ctl_bank.sv
module mmu_ctl_bank #(
  parameter int DW      = 32,
  parameter int AW      = 4,
  parameter int INV_BIT = 2,
  parameter int ASID_W  = 8,
  parameter int ASST_W  = 4,
  parameter int CODE_W  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rd_err,
  output logic          inv_pulse,
  output logic          flush_pulse
);
  localparam logic [AW-1:0] A_CTL  = AW'(0);
  localparam logic [AW-1:0] A_HI   = AW'(1);
  localparam logic [AW-1:0] A_LO   = AW'(2);
  localparam logic [AW-1:0] A_ASST = AW'(3);
  localparam logic [AW-1:0] A_BASE = AW'(4);
  localparam logic [AW-1:0] A_FALT = AW'(5);
  localparam logic [AW-1:0] A_TRAP = AW'(6);
  localparam logic [AW-1:0] A_EXC  = AW'(7);
  localparam logic [AW-1:0] A_INT  = AW'(8);
  localparam logic [DW-1:0] INV_M  = DW'(1) << INV_BIT;

  logic [DW-1:0]     ctl_q, hi_q, lo_q, base_q, falt_q;
  logic [ASST_W-1:0] asst_q;
  logic [CODE_W-1:0] trap_q, exc_q, int_q;
  logic              mapped;

  assign mapped = (addr <= A_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      asst_q      <= '0;
      base_q      <= '0;
      falt_q      <= '0;
      trap_q      <= '0;
      exc_q       <= '0;
      int_q       <= '0;
      inv_pulse   <= 1'b0;
      flush_pulse <= 1'b0;
    end else begin
      inv_pulse   <= wr_en && (addr == A_CTL) && wdata[INV_BIT];
      flush_pulse <= wr_en && (addr == A_HI) &&
                     (wdata[ASID_W-1:0] != hi_q[ASID_W-1:0]);
      if (wr_en) begin
        case (addr)
          A_CTL:   ctl_q  <= wdata & ~INV_M;
          A_HI:    hi_q   <= wdata;
          A_LO:    lo_q   <= wdata;
          A_ASST:  asst_q <= wdata[ASST_W-1:0];
          A_BASE:  base_q <= wdata;
          A_FALT:  falt_q <= wdata;
          A_TRAP:  trap_q <= wdata[CODE_W-1:0];
          A_EXC:   exc_q  <= wdata[CODE_W-1:0];
          A_INT:   int_q  <= wdata[CODE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTL:   rdata = ctl_q;
        A_HI:    rdata = hi_q;
        A_LO:    rdata = lo_q;
        A_ASST:  rdata = DW'(asst_q);
        A_BASE:  rdata = base_q;
        A_FALT:  rdata = falt_q;
        A_TRAP:  rdata = DW'(trap_q);
        A_EXC:   rdata = DW'(exc_q);
        A_INT:   rdata = DW'(int_q);
        default: rdata = '0;
      endcase
    end
  end

  assign rd_err = rd_en && !mapped;
endmodule

// File: rtl/mmu_ctl_bank_chk.sv
module mmu_ctl_bank_chk #(
  parameter int DW      = 32,
  parameter int AW      = 4,
  parameter int INV_BIT = 2,
  parameter int ASID_W  = 8,
  parameter int ASST_W  = 4,
  parameter int CODE_W  = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          rd_err,
  input logic          inv_pulse,
  input logic          flush_pulse
);
  p_inv_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |-> $past(wr_en && addr == AW'(0) && wdata[INV_BIT]));

  p_inv_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0) && wdata[INV_BIT]) |=> inv_pulse);

  p_inv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(0)) |-> !rdata[INV_BIT]);

  p_flush_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(wr_en && addr == AW'(1)));

  p_asst_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(3)) |-> (rdata >> ASST_W) == '0);

  p_code_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= AW'(6) && addr <= AW'(8)) |-> (rdata >> CODE_W) == '0);

  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rdata == '0 && rd_en));

  p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > AW'(8)) |=> (!inv_pulse && !flush_pulse));
endmodule

bind mmu_ctl_bank mmu_ctl_bank_chk #(
  .DW(DW), .AW(AW), .INV_BIT(INV_BIT), .ASID_W(ASID_W),
  .ASST_W(ASST_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rd_err(rd_err), .inv_pulse(inv_pulse),
  .flush_pulse(flush_pulse)
);

// File: tb/tb_mmu_ctl_bank.sv
module tb_mmu_ctl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_err;
  logic        inv_pulse;
  logic        flush_pulse;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [0:8];

  always #5 clk = ~clk;

  mmu_ctl_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_err(rd_err), .inv_pulse(inv_pulse),
    .flush_pulse(flush_pulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep(int a, logic [31:0] d);
    case (a)
      0:       return d & 32'hFFFF_FFFB;
      3:       return d & 32'h0000_000F;
      6, 7, 8: return d & 32'h0000_07FF;
      default: return d;
    endcase
  endfunction

  task automatic do_write(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a <= 8) model[a] = keep(a, d);
  endtask

  task automatic do_read(int a, output logic [31:0] d, output logic e);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    #1;
    d = rdata; e = rd_err;
    rd_en = 1'b0;
  endtask

  task automatic check_map(string req);
    logic [31:0] d;
    logic e;
    for (int i = 0; i <= 8; i++) begin
      do_read(i, d, e);
      check(req, d, model[i]);
      check({req, " err"}, 32'(e), 32'd0);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i <= 8; i++) model[i] = '0;
    check("R1 inv", 32'(inv_pulse), 0);
    check("R1 flush", 32'(flush_pulse), 0);
    check_map("R1");
  endtask

  task automatic t_invalidate;
    logic [31:0] d;
    logic e;
    do_write(0, 32'hFFFF_FFFF);
    check("R2 inv high", 32'(inv_pulse), 1);
    @(negedge clk);
    check("R2 inv one cycle", 32'(inv_pulse), 0);
    do_read(0, d, e);
    check("R3 bit clear", d, 32'hFFFF_FFFB);
    do_write(0, 32'h0000_0003);
    check("R2 no inv", 32'(inv_pulse), 0);
    do_read(0, d, e);
    check("R3 stored", d, 32'h0000_0003);
  endtask

  task automatic t_asid_flush;
    logic [31:0] d;
    logic e;
    do_write(1, 32'h0000_0000);
    check("R4 same id", 32'(flush_pulse), 0);
    do_write(1, 32'h0000_0012);
    check("R4 new id", 32'(flush_pulse), 1);
    @(negedge clk);
    check("R4 one cycle", 32'(flush_pulse), 0);
    do_write(1, 32'hABCD_0012);
    check("R4 upper only", 32'(flush_pulse), 0);
    do_read(1, d, e);
    check("R4 stored", d, 32'hABCD_0012);
    do_write(1, 32'hABCD_0013);
    check("R4 low change", 32'(flush_pulse), 1);
    check("R4 no inv", 32'(inv_pulse), 0);
  endtask

  task automatic t_masks;
    do_write(3, 32'hFFFF_FFFF);
    do_write(6, 32'hFFFF_FFFF);
    do_write(7, 32'hFFFF_F123);
    do_write(8, 32'h8000_0555);
    check("R5 assist", model[3], 32'h0000_000F);
    check_map("R5 R6 masks");
  endtask

  task automatic t_full;
    do_write(2, 32'hDEAD_BEEF);
    do_write(4, 32'h1234_5678);
    do_write(5, 32'hF00D_CAFE);
    check_map("R7 full");
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic e;
    for (int a = 9; a <= 15; a++) begin
      do_write(a, 32'hFFFF_FFFF);
      check("R8 no inv", 32'(inv_pulse), 0);
      check("R8 no flush", 32'(flush_pulse), 0);
      do_read(a, d, e);
      check("R8 data", d, 0);
      check("R8 err", 32'(e), 1);
    end
    check_map("R8 untouched");
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_invalidate;
    t_asid_flush;
    t_masks;
    t_full;
    t_unmapped;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule